// File: doc/BRIEF.md
# Receive Idle Timeout Counter

This block is one channel's counter/timer with a receive-driven time-out mode. In the normal mode it is a plain down-counter that software starts and stops by command. It loads a 16-bit value built from two 8-bit preset registers, counts down on each counter clock enable, and raises a ready flag at terminal count. In time-out mode, software start/stop commands are ignored and the receive data stream drives the counter. Each time the receiver moves a character into its FIFO, the counter halts for one counter clock, reloads from the presets and resumes on the next counter clock. If the line stays quiet until the count runs out, the ready flag is set. With the mask enabled, an interrupt request follows.

Firmware programs the presets to slightly more than one character time. It then arms time-out mode. It is then told about data left sitting in the FIFO, or about a line that has gone idle, without polling. The receiver, the FIFO and the counter clock source are outside this block. The block only sees a one-cycle transfer strobe and a one-cycle counter clock enable.

States: `ST_IDLE` (normal mode, stopped), `ST_RUN` (normal mode, counting), `ST_ARMED` (time-out mode, waiting for the first character), `ST_HALT` (a character was transferred, held for one counter clock), `ST_LOADED` (reloaded, waiting one counter clock to restart), `ST_COUNT` (time-out counting), `ST_EXPIRED` (time-out count ran out, stopped at zero).

Transitions:
- The time-out-on command goes from any state to `ST_ARMED`.
- The time-out-off command goes from any state to `ST_IDLE`.
- Start goes from `ST_IDLE` or `ST_RUN` to `ST_RUN`. Stop goes from `ST_RUN` to `ST_IDLE`.
- On a counter clock, terminal count goes from `ST_RUN` to `ST_IDLE`.
- A transfer strobe goes from any time-out state to `ST_HALT`.
- On a counter clock, `ST_HALT` goes to `ST_LOADED`, `ST_LOADED` goes to `ST_COUNT`, and terminal count goes from `ST_COUNT` to `ST_EXPIRED`.

Top module: `rx_idle_timeout`

## Requirements
- R1: A command write whose upper nibble is 0xA sets `timeout_mode` on the next clock. One whose upper nibble is 0xC clears `timeout_mode`. Both also clear `counter_ready`.
- R2: After time-out mode is armed, `count` holds its value through any number of counter clocks until a character transfer arrives.
- R3: After a transfer strobe in time-out mode, the first counter clock leaves `count` unchanged and loads {upper preset, lower preset} (upper preset in bits 15:8). The second counter clock leaves the reloaded value unchanged. Each later counter clock decrements it by one.
- R4: While counting, a counter clock with `count` at 1 or 0 drives `count` to 0 and sets `counter_ready`. `count` then stays at 0 and never wraps.
- R5: `counter_ready` stays set through further counter clocks and transfer strobes. Only the 0xA or 0xC commands clear it, and in normal mode also the start and stop commands.
- R6: `irq` is high exactly when `counter_ready` and `ready_mask` are both high, in the same cycle.
- R7: In time-out mode, start (upper nibble 0x8) and stop (upper nibble 0x9) commands change neither the mode nor the count.
- R8: In normal mode, a start command loads the presets into `count` and clears `counter_ready`. Counter clocks then decrement it. A stop command halts it and clears `counter_ready`. Transfer strobes have no effect.
- R9: A transfer strobe in the same cycle as the terminal counter clock wins: `counter_ready` stays clear and the count holds until the reload.
- R10: Preset writes are accepted at any time, leave the running count untouched, and are used at the next reload.
- R11: After reset, `count`, `counter_ready`, `timeout_mode` and `irq` are all 0, and both presets are 0.
- R12: A 0xA or 0xC command in the same cycle as a transfer strobe takes effect, and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte; upper nibble selects the operation |
| preset_hi_we | input | 1 | Write strobe for the upper preset byte |
| preset_lo_we | input | 1 | Write strobe for the lower preset byte |
| preset_data | input | 8 | Preset write data |
| char_xfer | input | 1 | One-cycle strobe: a character entered the receive FIFO |
| cnt_tick | input | 1 | Counter clock enable |
| ready_mask | input | 1 | Interrupt mask for the ready flag |
| count | output | 16 | Current counter value |
| timeout_mode | output | 1 | Time-out mode active |
| counter_ready | output | 1 | Counter reached terminal count |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state shows up as a `count` that moves when it should hold or holds when it should move. It shows up at the very next counter clock, as in `ST_ARMED`, `ST_HALT` versus `ST_LOADED`, or a missed reload. A wrong mode shows up on `timeout_mode` one clock after the command. A lost or stray ready flag shows up on `counter_ready` and `irq` at the terminal counter clock, or at the first command that should have left it alone. The bench compares all four outputs every clock, so a divergence is caught in the cycle where it first appears.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_ARMED,
        ST_HALT,
        ST_LOADED,
        ST_COUNT,
        ST_EXPIRED
    } tmr_state_e;

    localparam logic [3:0] OP_START  = 4'h8;
    localparam logic [3:0] OP_STOP   = 4'h9;
    localparam logic [3:0] OP_TO_ON  = 4'hA;
    localparam logic [3:0] OP_TO_OFF = 4'hC;

    typedef struct packed {
        logic to_on;
        logic to_off;
        logic start;
        logic stop;
    } cmd_t;

endpackage

// File: rtl/rxto_cmd_decode.sv
module rxto_cmd_decode
    import rxto_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    output cmd_t             cmd
);
    localparam int OP_MSB = CMD_W - 1;

    logic [3:0] opcode;

    always_comb begin
        opcode       = cmd_data[OP_MSB -: 4];
        cmd.to_on    = cmd_we && (opcode == OP_TO_ON);
        cmd.to_off   = cmd_we && (opcode == OP_TO_OFF);
        cmd.start    = cmd_we && (opcode == OP_START);
        cmd.stop     = cmd_we && (opcode == OP_STOP);
    end
endmodule

// File: rtl/rxto_preset_regs.sv
module rxto_preset_regs #(
    parameter int PRESET_W = 8,
    parameter int NUM_SEG  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SEG-1:0]           seg_we,
    input  logic [PRESET_W-1:0]          wdata,
    output logic [NUM_SEG*PRESET_W-1:0]  reload_val
);
    logic [PRESET_W-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (seg_we[g]) begin
                seg_q[g] <= wdata;
            end
        end
        assign reload_val[g*PRESET_W +: PRESET_W] = seg_q[g];
    end
endmodule

// File: rtl/rxto_fsm.sv
module rxto_fsm
    import rxto_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic             char_xfer,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             ready,
    output logic             to_mode,
    output tmr_state_e       state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_n;
    logic [CNT_W-1:0] count_n;
    logic             ready_n;
    logic             terminal;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
            ready <= 1'b0;
        end else begin
            state <= state_n;
            count <= count_n;
            ready <= ready_n;
        end
    end

    // next state
    always_comb begin
        state_n  = state;
        count_n  = count;
        ready_n  = ready;
        terminal = (count <= ONE);
        if (cmd.to_on) begin
            state_n = ST_ARMED;
            ready_n = 1'b0;
        end else if (cmd.to_off) begin
            state_n = ST_IDLE;
            ready_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd.start) begin
                        state_n = ST_RUN;
                        count_n = reload_val;
                        ready_n = 1'b0;
                    end else if (cmd.stop) begin
                        ready_n = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (cmd.start) begin
                        count_n = reload_val;
                        ready_n = 1'b0;
                    end else if (cmd.stop) begin
                        state_n = ST_IDLE;
                        ready_n = 1'b0;
                    end else if (cnt_tick) begin
                        if (terminal) begin
                            count_n = '0;
                            ready_n = 1'b1;
                            state_n = ST_IDLE;
                        end else begin
                            count_n = count - ONE;
                        end
                    end
                end
                ST_ARMED, ST_EXPIRED: begin
                    if (char_xfer) begin
                        state_n = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (char_xfer) begin
                        state_n = ST_HALT;
                    end else if (cnt_tick) begin
                        count_n = reload_val;
                        state_n = ST_LOADED;
                    end
                end
                ST_LOADED: begin
                    if (char_xfer) begin
                        state_n = ST_HALT;
                    end else if (cnt_tick) begin
                        state_n = ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (char_xfer) begin
                        state_n = ST_HALT;
                    end else if (cnt_tick) begin
                        if (terminal) begin
                            count_n = '0;
                            ready_n = 1'b1;
                            state_n = ST_EXPIRED;
                        end else begin
                            count_n = count - ONE;
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ARMED, ST_HALT, ST_LOADED, ST_COUNT, ST_EXPIRED: to_mode = 1'b1;
            default:                                            to_mode = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int PRESET_W = 8,
    parameter int CMD_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_we,
    input  logic [CMD_W-1:0]      cmd_data,
    input  logic                  preset_hi_we,
    input  logic                  preset_lo_we,
    input  logic [PRESET_W-1:0]   preset_data,
    input  logic                  char_xfer,
    input  logic                  cnt_tick,
    input  logic                  ready_mask,
    output logic [2*PRESET_W-1:0] count,
    output logic                  timeout_mode,
    output logic                  counter_ready,
    output logic                  irq
);
    localparam int NUM_SEG = 2;
    localparam int CNT_W   = NUM_SEG * PRESET_W;

    cmd_t             cmd;
    logic [CNT_W-1:0] reload_val;
    tmr_state_e       fsm_state;

    rxto_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .cmd      (cmd)
    );

    rxto_preset_regs #(.PRESET_W(PRESET_W), .NUM_SEG(NUM_SEG)) u_preset (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_we     ({preset_hi_we, preset_lo_we}),
        .wdata      (preset_data),
        .reload_val (reload_val)
    );

    rxto_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .char_xfer  (char_xfer),
        .cnt_tick   (cnt_tick),
        .reload_val (reload_val),
        .count      (count),
        .ready      (counter_ready),
        .to_mode    (timeout_mode),
        .state      (fsm_state)
    );

    assign irq = counter_ready & ready_mask;
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker
    import rxto_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CMD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [CMD_W-1:0] cmd_data,
    input logic             char_xfer,
    input logic [CNT_W-1:0] count,
    input logic             timeout_mode,
    input logic             counter_ready,
    input logic             irq,
    input tmr_state_e       state
);
    logic [3:0] op;
    logic       clr_cmd;
    assign op      = cmd_data[CMD_W-1 -: 4];
    assign clr_cmd = cmd_we && ((op == OP_TO_ON) || (op == OP_TO_OFF) ||
                     (!timeout_mode && ((op == OP_START) || (op == OP_STOP))));

    p_exit_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && op == OP_TO_OFF) |=> (!timeout_mode && !counter_ready));

    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && op == OP_TO_ON) |=> (timeout_mode && !counter_ready));

    p_armed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !char_xfer && !cmd_we) |=> ($stable(count) && state == ST_ARMED));

    p_ready_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(counter_ready) |-> (count == '0));

    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (counter_ready && !clr_cmd) |=> counter_ready);

    p_irq_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> counter_ready);

    p_ignore_startstop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_mode && cmd_we && (op == OP_START || op == OP_STOP)) |=> timeout_mode);

    p_tie_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_mode && char_xfer && !cmd_we && !counter_ready) |=> !counter_ready);
endmodule

bind rx_idle_timeout rxto_checker #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_data      (cmd_data),
    .char_xfer     (char_xfer),
    .count         (count),
    .timeout_mode  (timeout_mode),
    .counter_ready (counter_ready),
    .irq           (irq),
    .state         (fsm_state)
);

// File: tb/rx_idle_timeout_tb_top.sv
module rx_idle_timeout_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        preset_hi_we = 1'b0;
    logic        preset_lo_we = 1'b0;
    logic [7:0]  preset_data = '0;
    logic        char_xfer = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        ready_mask = 1'b0;
    logic [15:0] count;
    logic        timeout_mode;
    logic        counter_ready;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference: phase 0 stopped, 1 running, 2 armed, 3 halted,
    // 4 loaded, 5 counting, 6 expired
    int m_mode, m_phase, m_cnt, m_rdy, m_hi, m_lo;

    always #10 clk = ~clk;

    rx_idle_timeout dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_we        (cmd_we),
        .cmd_data      (cmd_data),
        .preset_hi_we  (preset_hi_we),
        .preset_lo_we  (preset_lo_we),
        .preset_data   (preset_data),
        .char_xfer     (char_xfer),
        .cnt_tick      (cnt_tick),
        .ready_mask    (ready_mask),
        .count         (count),
        .timeout_mode  (timeout_mode),
        .counter_ready (counter_ready),
        .irq           (irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int op = int'(cmd_data[7:4]);
        int pre = m_hi * 256 + m_lo;
        if (cmd_we && op == 10) begin
            m_mode = 1; m_phase = 2; m_rdy = 0;
        end else if (cmd_we && op == 12) begin
            m_mode = 0; m_phase = 0; m_rdy = 0;
        end else if (m_mode == 0) begin
            if (cmd_we && op == 8) begin
                m_cnt = pre; m_phase = 1; m_rdy = 0;
            end else if (cmd_we && op == 9) begin
                m_phase = 0; m_rdy = 0;
            end else if (m_phase == 1 && cnt_tick) begin
                if (m_cnt <= 1) begin m_cnt = 0; m_rdy = 1; m_phase = 0; end
                else m_cnt = m_cnt - 1;
            end
        end else if (char_xfer) begin
            m_phase = 3;
        end else if (cnt_tick) begin
            if (m_phase == 3) begin m_cnt = pre; m_phase = 4; end
            else if (m_phase == 4) m_phase = 5;
            else if (m_phase == 5) begin
                if (m_cnt <= 1) begin m_cnt = 0; m_rdy = 1; m_phase = 6; end
                else m_cnt = m_cnt - 1;
            end
        end
        if (preset_hi_we) m_hi = int'(preset_data);
        if (preset_lo_we) m_lo = int'(preset_data);
    endtask

    task automatic compare_all();
        int exp_irq = (m_rdy != 0 && ready_mask) ? 1 : 0;
        chk(int'(count) == m_cnt, "R3/R4/R10 count vs model", int'(count), m_cnt);
        chk(int'(counter_ready) == m_rdy, "R5 ready vs model", int'(counter_ready), m_rdy);
        chk(int'(irq) == exp_irq, "R6 irq vs model", int'(irq), exp_irq);
        chk(int'(timeout_mode) == m_mode, "R1 mode vs model", int'(timeout_mode), m_mode);
    endtask

    task automatic cyc(input logic cw, input logic [7:0] cd, input logic hw, input logic lw,
                       input logic [7:0] pd, input logic ch, input logic tk);
        cmd_we = cw; cmd_data = cd; preset_hi_we = hw; preset_lo_we = lw;
        preset_data = pd; char_xfer = ch; cnt_tick = tk;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cmd_we = 1'b0; preset_hi_we = 1'b0; preset_lo_we = 1'b0;
        char_xfer = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 8'h00, 0, 1);
    endtask

    task automatic command(input logic [7:0] cd);
        cyc(1, cd, 0, 0, 8'h00, 0, 0);
    endtask

    task automatic xfer();
        cyc(0, 8'h00, 0, 0, 8'h00, 1, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_phase = 0; m_cnt = 0; m_rdy = 0; m_hi = 0; m_lo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(count == 16'd0, "R11 count after reset", int'(count), 0);
        chk(counter_ready == 1'b0 && irq == 1'b0, "R11 ready/irq after reset", int'(counter_ready), 0);
        chk(timeout_mode == 1'b0, "R11 mode after reset", int'(timeout_mode), 0);
        compare_all();

        // R8 normal mode start and countdown, R4 terminal count
        cyc(0, 8'h00, 1, 0, 8'h00, 0, 0);
        cyc(0, 8'h00, 0, 1, 8'h05, 0, 0);
        command(8'h80);
        chk(count == 16'd5, "R8 start loads presets", int'(count), 5);
        ticks(4);
        chk(count == 16'd1 && !counter_ready, "R8 normal countdown", int'(count), 1);
        ticks(1);
        chk(count == 16'd0 && counter_ready, "R4 terminal sets ready", int'(counter_ready), 1);
        ticks(3);
        chk(count == 16'd0, "R4 no wrap below zero", int'(count), 0);
        xfer();
        chk(!timeout_mode && counter_ready && count == 16'd0, "R8 transfer ignored in normal mode",
            int'(timeout_mode), 0);

        // R6 interrupt gating
        ready_mask = 1'b1;
        #1;
        chk(irq == 1'b1, "R6 irq with mask set", int'(irq), 1);
        cyc(0, 8'h00, 0, 0, 8'h00, 0, 0);
        ready_mask = 1'b0;
        #1;
        chk(irq == 1'b0, "R6 irq with mask clear", int'(irq), 0);
        cyc(0, 8'h00, 0, 0, 8'h00, 0, 0);
        ready_mask = 1'b1;

        // R8 start clears ready, stop halts
        command(8'h80);
        chk(!counter_ready && count == 16'd5, "R8 start clears ready", int'(counter_ready), 0);
        ticks(2);
        command(8'h90);
        ticks(2);
        chk(count == 16'd3, "R8 stop halts count", int'(count), 3);

        // R1 / R2 arm, count held
        command(8'hA3);
        chk(timeout_mode == 1'b1, "R1 0xA enters time-out mode", int'(timeout_mode), 1);
        ticks(4);
        chk(count == 16'd3, "R2 armed count holds", int'(count), 3);

        // R7 start/stop ignored in time-out mode
        command(8'h80);
        chk(timeout_mode && count == 16'd3, "R7 start ignored", int'(count), 3);
        command(8'h95);
        ticks(1);
        chk(timeout_mode && count == 16'd3, "R7 stop ignored", int'(count), 3);

        // R10 preset write leaves count, R3 halt/reload/restart sequence
        cyc(0, 8'h00, 1, 0, 8'h01, 0, 0);
        cyc(0, 8'h00, 0, 1, 8'h02, 0, 0);
        chk(count == 16'd3, "R10 preset write leaves count", int'(count), 3);
        xfer();
        chk(count == 16'd3, "R3 halt after transfer", int'(count), 3);
        ticks(1);
        chk(count == 16'h0102, "R3 reload upper:lower", int'(count), 16'h0102);
        ticks(1);
        chk(count == 16'h0102, "R3 restart without decrement", int'(count), 16'h0102);
        ticks(1);
        chk(count == 16'h0101, "R3 decrement after restart", int'(count), 16'h0101);

        // R10 new presets at next reload
        cyc(0, 8'h00, 0, 1, 8'h04, 0, 0);
        cyc(0, 8'h00, 1, 0, 8'h00, 0, 0);
        chk(count == 16'h0101, "R10 running count untouched", int'(count), 16'h0101);
        xfer();
        ticks(2);
        chk(count == 16'd4, "R10 new preset used at reload", int'(count), 4);
        ticks(3);
        chk(count == 16'd1 && !counter_ready, "R4 counting toward zero", int'(count), 1);
        ticks(1);
        chk(count == 16'd0 && counter_ready && irq, "R4 time-out expiry", int'(counter_ready), 1);

        // R5 ready sticky
        ticks(2);
        xfer();
        chk(counter_ready == 1'b1, "R5 ready survives transfer", int'(counter_ready), 1);
        ticks(2);
        chk(counter_ready == 1'b1 && count == 16'd4, "R5 ready survives reload", int'(counter_ready), 1);
        command(8'hA0);
        chk(!counter_ready && timeout_mode && count == 16'd4, "R2 rearm clears ready",
            int'(counter_ready), 0);

        // R9 transfer coinciding with terminal tick
        xfer();
        ticks(2);
        ticks(3);
        chk(count == 16'd1, "R9 setup count at one", int'(count), 1);
        cyc(0, 8'h00, 0, 0, 8'h00, 1, 1);
        chk(!counter_ready && count == 16'd1, "R9 transfer beats terminal", int'(counter_ready), 0);
        ticks(1);
        chk(!counter_ready && count == 16'd4, "R9 reload after tie", int'(count), 4);

        // R12 mode command wins over transfer
        cyc(1, 8'hC0, 0, 0, 8'h00, 1, 0);
        ticks(1);
        chk(!timeout_mode && count == 16'd4, "R12 exit with transfer", int'(timeout_mode), 0);
        cyc(1, 8'hA0, 0, 0, 8'h00, 1, 0);
        ticks(3);
        chk(timeout_mode && count == 16'd4, "R12 arm drops transfer", int'(count), 4);

        // R1 exit clears ready
        xfer();
        ticks(2);
        ticks(4);
        chk(counter_ready == 1'b1, "R1 setup ready", int'(counter_ready), 1);
        command(8'hC5);
        chk(!timeout_mode && !counter_ready && !irq, "R1 0xC exit clears ready",
            int'(counter_ready), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule